// File: doc/BRIEF.md
# DMA Channel Register Bank with Interrupt Flags

This block is the software-visible register bank of a multi-channel DMA controller. A simple 32-bit bus with a word address reaches a small set of global registers and, for each channel, five 32-bit words: source address, destination address, next-descriptor pointer, control and configuration. The transfer engine is outside this block. It raises single-cycle pulses to report that a channel has reached its terminal count or has hit an error. The bank latches those pulses as raw flags, and software clears them by writing ones.

Each channel's interrupt enables are not separate registers. Bit 15 of a channel's configuration word enables its terminal-count interrupt and bit 14 enables its error interrupt. Three level outputs are driven from the masked flags: error, terminal count, and their OR. Bit 0 of each configuration word is the channel enable, and a global word shows these enables as a bitmap. An identification window at the top of the map returns one byte of a fixed 64-bit constant per word. Reads of unknown locations return zero and writes to them are dropped.

Top module: `dma_regbank`

## Requirements
- R1: After reset every channel word, the global configuration and sync words, both raw flag sets and all three interrupt outputs are zero.
- R2: A channel word sits at byte offset 0x100 + 32*channel + 4*slot, with slot 0 source, 1 destination, 2 next pointer, 3 control and 4 configuration. A write stores all 32 bits and a later read returns them.
- R3: A read returns zero, and a write changes no register, in these cases: the channel field (byte offset bits 7:5) is at or above NUM_CH, the slot is 5 to 7, the offset is a global word other than 0 to 7, 12 or 13 (this includes the software request words 8 to 11), or the offset lies between 0x200 and 0xFDF.
- R4: The global configuration word (0x030) and the sync word (0x034) store and return all 32 bits.
- R5: A one on bit c of tc_set or err_set in a cycle sets raw flag c. The raw terminal-count flags read at 0x014 and the raw error flags read at 0x018, one bit per channel starting at bit 0.
- R6: Writing to 0x008 clears each raw terminal-count flag whose data bit is one, and writing to 0x010 does the same for the raw error flags. Flags whose data bit is zero keep their value.
- R7: When a set pulse and a clear write reach the same flag in the same cycle, the flag ends up set.
- R8: The terminal-count mask of channel c is bit 15 of its configuration word and its error mask is bit 14. The masked terminal-count flags read at 0x004, the masked error flags at 0x00C, and their bitwise OR at 0x000.
- R9: irq_tc is high exactly when some masked terminal-count flag is set, irq_err exactly when some masked error flag is set, and irq_any is their OR. All three follow the register state without added delay.
- R10: The word at 0x01C holds bit 0 of channel c's configuration word in bit c.
- R11: A read from byte offset 0xFE0 to 0xFFF returns, in bits 7:0, byte k of ID_CODE (bits 8k+7:8k), where k is byte offset bits 4:2. The upper 24 bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Word address (byte offset bits 11:2) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address during a read |
| tc_set | input | NUM_CH | Terminal-count pulse per channel |
| err_set | input | NUM_CH | Error pulse per channel |
| irq_err | output | 1 | Masked error interrupt level |
| irq_tc | output | 1 | Masked terminal-count interrupt level |
| irq_any | output | 1 | OR of the two interrupt levels |

## Verification
The bench uses the two-channel configuration. It writes a distinct pattern to every combination of the eight channel fields and eight slots, then reads every one back. This separates true decoding from channels that alias modulo the channel count and from slots that are accepted when they should not be. With both raw flag sets full, it sweeps all sixteen enable-bit combinations of the two configuration words. Each masked status word and each output is compared with an expected value computed arithmetically, which tells the terminal-count mask bit from the error mask bit. Clears are tried with partial, full and empty data words, and once with a set pulse in the same cycle, to separate per-bit clearing and set priority from whole-register clearing.

// File: rtl/dma_regbank_pkg.sv
package dma_regbank_pkg;

    localparam int WORD_W      = 32;
    localparam int WADDR_W     = 10;
    localparam int CFG_EN_BIT  = 0;
    localparam int CFG_EIE_BIT = 14;
    localparam int CFG_TIE_BIT = 15;
    localparam int NUM_SLOTS   = 5;

    typedef enum logic [2:0] {
        SLOT_SRC  = 3'd0,
        SLOT_DST  = 3'd1,
        SLOT_NEXT = 3'd2,
        SLOT_CTRL = 3'd3,
        SLOT_CFG  = 3'd4
    } slot_e;

    typedef enum logic [5:0] {
        GW_STAT     = 6'd0,
        GW_TC_STAT  = 6'd1,
        GW_TC_CLR   = 6'd2,
        GW_ERR_STAT = 6'd3,
        GW_ERR_CLR  = 6'd4,
        GW_TC_RAW   = 6'd5,
        GW_ERR_RAW  = 6'd6,
        GW_ENABLED  = 6'd7,
        GW_CONFIG   = 6'd12,
        GW_SYNC     = 6'd13
    } gword_e;

    typedef enum logic [1:0] {
        RGN_NONE   = 2'd0,
        RGN_GLOBAL = 2'd1,
        RGN_CHAN   = 2'd2,
        RGN_ID     = 2'd3
    } region_e;

    typedef struct packed {
        region_e     region;
        logic [2:0]  chan;
        logic [2:0]  slot;
        logic [5:0]  gword;
        logic [2:0]  id_idx;
    } dec_t;

    typedef struct packed {
        logic [WORD_W-1:0] src;
        logic [WORD_W-1:0] dst;
        logic [WORD_W-1:0] next;
        logic [WORD_W-1:0] ctrl;
        logic [WORD_W-1:0] cfg;
    } chan_t;

    function automatic logic gword_ok(input logic [5:0] w);
        logic ok;
        case (w)
            GW_STAT, GW_TC_STAT, GW_TC_CLR, GW_ERR_STAT, GW_ERR_CLR,
            GW_TC_RAW, GW_ERR_RAW, GW_ENABLED, GW_CONFIG, GW_SYNC: ok = 1'b1;
            default: ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/dma_addr_decode.sv
module dma_addr_decode
    import dma_regbank_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic [WADDR_W-1:0] waddr,
    output dec_t               dec
);
    logic chan_in_range;
    logic slot_in_range;

    always_comb begin
        chan_in_range = ({29'd0, waddr[5:3]} < NUM_CH);
        slot_in_range = ({29'd0, waddr[2:0]} < NUM_SLOTS);
        dec.chan   = waddr[5:3];
        dec.slot   = waddr[2:0];
        dec.gword  = waddr[5:0];
        dec.id_idx = waddr[2:0];
        if (waddr[9:6] == 4'h1) begin
            dec.region = (chan_in_range && slot_in_range) ? RGN_CHAN : RGN_NONE;
        end else if (waddr[9:3] == 7'h7F) begin
            dec.region = RGN_ID;
        end else if (waddr[9:6] == 4'h0 && gword_ok(waddr[5:0])) begin
            dec.region = RGN_GLOBAL;
        end else begin
            dec.region = RGN_NONE;
        end
    end

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_regbank_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_fire,
    input  dec_t              dec,
    input  logic [WORD_W-1:0] wdata,
    output chan_t             chans [NUM_CH]
);
    logic [NUM_CH-1:0] ch_we;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign ch_we[c] = wr_fire && (dec.region == RGN_CHAN) && (dec.chan == 3'(c));

        always_ff @(posedge clk) begin
            if (rst) begin
                chans[c] <= '0;
            end else if (ch_we[c]) begin
                case (dec.slot)
                    SLOT_SRC:  chans[c].src  <= wdata;
                    SLOT_DST:  chans[c].dst  <= wdata;
                    SLOT_NEXT: chans[c].next <= wdata;
                    SLOT_CTRL: chans[c].ctrl <= wdata;
                    SLOT_CFG:  chans[c].cfg  <= wdata;
                    default:   ;
                endcase
            end
        end

        AST_CHAN_HOLD: assert property (@(posedge clk) disable iff (rst)
            !ch_we[c] |=> $stable(chans[c])); // R3
    end

endmodule

// File: rtl/dma_irq_flags.sv
module dma_irq_flags #(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] tc_set,
    input  logic [NUM_CH-1:0] err_set,
    input  logic              tc_clr_we,
    input  logic              err_clr_we,
    input  logic [NUM_CH-1:0] clr_mask,
    input  logic [NUM_CH-1:0] tc_mask,
    input  logic [NUM_CH-1:0] err_mask,
    output logic [NUM_CH-1:0] tc_raw,
    output logic [NUM_CH-1:0] err_raw,
    output logic              irq_tc,
    output logic              irq_err,
    output logic              irq_any
);
    logic [NUM_CH-1:0] tc_keep;
    logic [NUM_CH-1:0] err_keep;

    always_comb begin
        tc_keep  = tc_clr_we  ? ~clr_mask : '1;
        err_keep = err_clr_we ? ~clr_mask : '1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tc_raw  <= '0;
            err_raw <= '0;
        end else begin
            tc_raw  <= (tc_raw  & tc_keep)  | tc_set;
            err_raw <= (err_raw & err_keep) | err_set;
        end
    end

    always_comb begin
        irq_tc  = |(tc_raw & tc_mask);
        irq_err = |(err_raw & err_mask);
        irq_any = irq_tc | irq_err;
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (tc_set != '0) |=> ((tc_raw & $past(tc_set)) == $past(tc_set))); // R7

    AST_CLR_DROPS: assert property (@(posedge clk) disable iff (rst)
        tc_clr_we |=> ((tc_raw & $past(clr_mask) & ~$past(tc_set)) == '0)); // R6

    AST_ERR_NEEDS_RAW: assert property (@(posedge clk) disable iff (rst)
        irq_err |-> (err_raw != '0)); // R9

    AST_TC_NEEDS_RAW: assert property (@(posedge clk) disable iff (rst)
        irq_tc |-> (tc_raw != '0)); // R9

endmodule

// File: rtl/dma_regbank.sv
module dma_regbank
    import dma_regbank_pkg::*;
#(
    parameter int          NUM_CH  = 8,
    parameter logic [63:0] ID_CODE = 64'h5A3C_0F96_01D2_7E48
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [WADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0]  bus_wdata,
    output logic [WORD_W-1:0]  bus_rdata,
    input  logic [NUM_CH-1:0]  tc_set,
    input  logic [NUM_CH-1:0]  err_set,
    output logic               irq_err,
    output logic               irq_tc,
    output logic               irq_any
);
    dec_t              dec;
    chan_t             chans [NUM_CH];
    logic              wr_fire;
    logic              glb_we;
    logic [WORD_W-1:0] glb_cfg;
    logic [WORD_W-1:0] glb_sync;
    logic [NUM_CH-1:0] tc_mask, err_mask, ch_en;
    logic [NUM_CH-1:0] tc_raw, err_raw;

    assign wr_fire = bus_sel && bus_wr;
    assign glb_we  = wr_fire && (dec.region == RGN_GLOBAL);

    dma_addr_decode #(.NUM_CH(NUM_CH)) u_decode (
        .waddr (bus_addr),
        .dec   (dec)
    );

    dma_chan_regs #(.NUM_CH(NUM_CH)) u_chans (
        .clk     (clk),
        .rst     (rst),
        .wr_fire (wr_fire),
        .dec     (dec),
        .wdata   (bus_wdata),
        .chans   (chans)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_mask
        assign tc_mask[c]  = chans[c].cfg[CFG_TIE_BIT];
        assign err_mask[c] = chans[c].cfg[CFG_EIE_BIT];
        assign ch_en[c]    = chans[c].cfg[CFG_EN_BIT];
    end

    dma_irq_flags #(.NUM_CH(NUM_CH)) u_irq (
        .clk        (clk),
        .rst        (rst),
        .tc_set     (tc_set),
        .err_set    (err_set),
        .tc_clr_we  (glb_we && (dec.gword == GW_TC_CLR)),
        .err_clr_we (glb_we && (dec.gword == GW_ERR_CLR)),
        .clr_mask   (bus_wdata[NUM_CH-1:0]),
        .tc_mask    (tc_mask),
        .err_mask   (err_mask),
        .tc_raw     (tc_raw),
        .err_raw    (err_raw),
        .irq_tc     (irq_tc),
        .irq_err    (irq_err),
        .irq_any    (irq_any)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            glb_cfg  <= '0;
            glb_sync <= '0;
        end else if (glb_we) begin
            if (dec.gword == GW_CONFIG) glb_cfg  <= bus_wdata;
            if (dec.gword == GW_SYNC)   glb_sync <= bus_wdata;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            case (dec.region)
                RGN_CHAN: begin
                    case (dec.slot)
                        SLOT_SRC:  bus_rdata = chans[dec.chan].src;
                        SLOT_DST:  bus_rdata = chans[dec.chan].dst;
                        SLOT_NEXT: bus_rdata = chans[dec.chan].next;
                        SLOT_CTRL: bus_rdata = chans[dec.chan].ctrl;
                        SLOT_CFG:  bus_rdata = chans[dec.chan].cfg;
                        default:   bus_rdata = '0;
                    endcase
                end
                RGN_GLOBAL: begin
                    case (dec.gword)
                        GW_STAT:     bus_rdata = WORD_W'((tc_raw & tc_mask) | (err_raw & err_mask));
                        GW_TC_STAT:  bus_rdata = WORD_W'(tc_raw & tc_mask);
                        GW_ERR_STAT: bus_rdata = WORD_W'(err_raw & err_mask);
                        GW_TC_RAW:   bus_rdata = WORD_W'(tc_raw);
                        GW_ERR_RAW:  bus_rdata = WORD_W'(err_raw);
                        GW_ENABLED:  bus_rdata = WORD_W'(ch_en);
                        GW_CONFIG:   bus_rdata = glb_cfg;
                        GW_SYNC:     bus_rdata = glb_sync;
                        default:     bus_rdata = '0;
                    endcase
                end
                RGN_ID:  bus_rdata = {24'd0, ID_CODE[{dec.id_idx, 3'b000} +: 8]};
                default: bus_rdata = '0;
            endcase
        end
    end

    AST_ANY_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        irq_any |-> (tc_raw != '0 || err_raw != '0)); // R9

    AST_GLOBAL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !glb_we |=> ($stable(glb_cfg) && $stable(glb_sync))); // R3

endmodule

// File: tb/dma_regbank_bench.sv
module dma_regbank_bench;
    localparam int          NCH = 2;
    localparam logic [63:0] IDC = 64'h5A3C_0F96_01D2_7E48;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NCH-1:0] tc_set = '0;
    logic [NCH-1:0] err_set = '0;
    logic        irq_err, irq_tc, irq_any;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    dma_regbank #(.NUM_CH(NCH), .ID_CODE(IDC)) u_dma_regbank (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tc_set(tc_set), .err_set(err_set),
        .irq_err(irq_err), .irq_tc(irq_tc), .irq_any(irq_any)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] off, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = off[11:2]; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; tc_set = '0; err_set = '0;
    endtask

    task automatic rd(input logic [11:0] off, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = off[11:2];
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic pulse(input logic [NCH-1:0] t, input logic [NCH-1:0] e);
        @(negedge clk);
        tc_set = t; err_set = e;
        @(negedge clk);
        tc_set = '0; err_set = '0;
    endtask

    function automatic logic [31:0] pat(input int ch, input int sl);
        return 32'hC0DE_0000 ^ (32'(ch) << 24) ^ (32'(sl) << 20);
    endfunction

    task automatic check_irq(input string req, input logic t, input logic e);
        #1;
        check(req, {29'd0, irq_any, irq_tc, irq_err}, {29'd0, t | e, t, e});
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1: reset state
        for (int ch = 0; ch < NCH; ch++)
            for (int sl = 0; sl < 5; sl++) begin
                rd(12'h100 + 12'(ch * 32 + sl * 4), d);
                check("R1 chan word", d, 32'd0);
            end
        for (int w = 0; w < 14; w++) begin
            rd(12'(w * 4), d);
            check("R1 global word", d, 32'd0);
        end
        check_irq("R1 irq outputs", 1'b0, 1'b0);

        // R2 / R3: exhaustive channel and slot sweep
        for (int ch = 0; ch < 8; ch++)
            for (int sl = 0; sl < 8; sl++)
                wr(12'h100 + 12'(ch * 32 + sl * 4), pat(ch, sl));
        for (int ch = 0; ch < 8; ch++)
            for (int sl = 0; sl < 8; sl++) begin
                rd(12'h100 + 12'(ch * 32 + sl * 4), d);
                if (ch < NCH && sl < 5) check("R2 chan readback", d, pat(ch, sl));
                else                    check("R3 invalid chan or slot", d, 32'd0);
            end

        // R4: global config and sync
        wr(12'h030, 32'hDEAD_BEEF);
        wr(12'h034, 32'h1234_5678);
        rd(12'h030, d); check("R4 config", d, 32'hDEAD_BEEF);
        rd(12'h034, d); check("R4 sync", d, 32'h1234_5678);

        // R3: undefined globals, soft request words, gap region
        for (int w = 8; w < 12; w++) wr(12'(w * 4), 32'hFFFF_FFFF);
        wr(12'h038, 32'h0);
        wr(12'h0FC, 32'h0);
        wr(12'h200, 32'h0);
        wr(12'hFE0, 32'h0);
        for (int w = 8; w < 12; w++) begin
            rd(12'(w * 4), d); check("R3 soft request reads zero", d, 32'd0);
        end
        rd(12'h200, d); check("R3 gap reads zero", d, 32'd0);
        rd(12'h030, d); check("R3 config untouched", d, 32'hDEAD_BEEF);
        rd(12'h034, d); check("R3 sync untouched", d, 32'h1234_5678);
        rd(12'h100, d); check("R3 chan0 untouched", d, pat(0, 0));
        rd(12'h120, d); check("R3 chan1 untouched", d, pat(1, 0));

        // R10: enabled bitmap
        wr(12'h110, 32'h0000_0001);
        wr(12'h130, 32'h0000_0000);
        rd(12'h01C, d); check("R10 enabled ch0", d, 32'h1);
        wr(12'h110, 32'h0);
        wr(12'h130, 32'h1);
        rd(12'h01C, d); check("R10 enabled ch1", d, 32'h2);

        // R5: set pulses into raw flags (masks off)
        pulse(2'b10, 2'b00);
        rd(12'h014, d); check("R5 raw tc", d, 32'h2);
        rd(12'h018, d); check("R5 raw err untouched", d, 32'h0);
        check_irq("R9 masked off", 1'b0, 1'b0);
        pulse(2'b01, 2'b11);
        rd(12'h014, d); check("R5 raw tc accumulate", d, 32'h3);
        rd(12'h018, d); check("R5 raw err", d, 32'h3);

        // R8 / R9: sweep all mask combinations with every raw flag set
        for (int m = 0; m < 16; m++) begin
            logic [1:0] tm, em;
            tm = {m[2], m[0]};
            em = {m[3], m[1]};
            wr(12'h110, {16'd0, m[0], m[1], 14'd0});
            wr(12'h130, {16'd0, m[2], m[3], 14'd0});
            rd(12'h004, d); check("R8 masked tc", d, {30'd0, tm});
            rd(12'h00C, d); check("R8 masked err", d, {30'd0, em});
            rd(12'h000, d); check("R8 combined", d, {30'd0, tm | em});
            check_irq("R9 outputs", |tm, |em);
        end

        // R6: per-bit clear
        wr(12'h110, 32'h0000_C000);
        wr(12'h130, 32'h0000_C000);
        wr(12'h008, 32'h0000_0000);
        rd(12'h014, d); check("R6 clear zeros keep", d, 32'h3);
        wr(12'h008, 32'h0000_0001);
        rd(12'h014, d); check("R6 clear bit0", d, 32'h2);
        rd(12'h018, d); check("R6 err unaffected", d, 32'h3);
        wr(12'h008, 32'hFFFF_FFFF);
        rd(12'h014, d); check("R6 clear all tc", d, 32'h0);
        check_irq("R9 err only", 1'b0, 1'b1);
        wr(12'h010, 32'h0000_0002);
        rd(12'h018, d); check("R6 clear err bit1", d, 32'h1);
        wr(12'h010, 32'h0000_0001);
        check_irq("R9 all clear", 1'b0, 1'b0);

        // R7: set wins over same-cycle clear
        pulse(2'b11, 2'b00);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 10'h002; bus_wdata = 32'h3; tc_set = 2'b01;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; tc_set = '0;
        rd(12'h014, d); check("R7 set wins over clear", d, 32'h1);

        // R11: identification bytes
        for (int k = 0; k < 8; k++) begin
            rd(12'hFE0 + 12'(k * 4), d);
            check("R11 id byte", d, {24'd0, IDC[k*8 +: 8]});
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule